// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block sits beside a small 8-bit microcontroller core. It controls the oscillator enable and the gated clocks of the core and its peripherals. When the core writes the power-down control bit, the sequencer stops the oscillator and both clock domains at the next clock edge. The instruction that did the write is therefore the last one the core executes.

Two events can end power-down. The first is an external interrupt on one of the active-low request lines, and it only counts if that line is enabled, set to level-sensitive mode and assigned the top priority. The second is the chip reset pin, which clears the power-down bit and turns the oscillator back on without waiting for a clock edge.

Either wake restarts the oscillator and waits a fixed number of stabilization cycles before it re-opens the clocks. It then tells the core when to resume and which path follows. After an interrupt wake the core enters the service routine, but only once the waking line has been released. After a reset wake the core runs on briefly and a reset vector is pending. Internal RAM access stays blocked from the moment the clocks are restored until the resume grant, while port access is left alone.

Top module: `pd_wake_ctrl`

## Requirements
- R1: Out of reset, the outputs are: `pd_bit_o`=0, `osc_enable_o`=1, `cpu_clk_en_o`=1, `periph_clk_en_o`=1, `ram_block_o`=0, `resume_o`=0, `resume_isr_o`=0 and `reset_pending_o`=0.
- R2: A one-cycle `pd_set_i` while the core is running and `chip_rst_i` is low has these effects at the next clock edge:
  - `pd_bit_o` goes to 1;
  - `osc_enable_o`, `cpu_clk_en_o` and `periph_clk_en_o` go to 0;
  - `resume_isr_o` goes to 0.

  The clocks stay off for as long as power-down lasts.
- R3: While powered down, interrupt line k wakes the block only under all of the following conditions:
  - `int_n_i[k]` is 0;
  - `int_en_i[k]` is 1;
  - `int_level_i[k]` is 1 (1 means level-sensitive, 0 means edge);
  - `int_hipri_i[k]` is 1 (1 means top priority).

  A request that fails any of these leaves `pd_bit_o` at 1 and `osc_enable_o` at 0.
- R4: The edge that samples a qualifying request clears `pd_bit_o` and sets `osc_enable_o`. The clocks stay off during the wait. Exactly `STAB_CYCLES` edges later, `cpu_clk_en_o` and `periph_clk_en_o` return to 1.
- R5: After an interrupt wake, `resume_o` is a one-cycle pulse. It comes at the first edge after clock restore at which the waking line is sampled high. If the line was already released during the wait, that is the edge right after restore. `resume_isr_o` becomes 1 with the pulse and holds until the next power-down entry.
- R6: `chip_rst_i` high clears `pd_bit_o` to 0 and sets `osc_enable_o` to 1 without any clock edge. `pd_bit_o` stays 0 while `chip_rst_i` is high.
- R7: A reset wake proceeds as follows:
  - `reset_pending_o` rises at the first edge after the reset.
  - The clocks return `STAB_CYCLES` edges later.
  - `resume_o` pulses at the next edge whether or not `chip_rst_i` is still high.
  - `resume_isr_o` stays 0 throughout.
  - `reset_pending_o` holds until `reset_ack_i` is seen while running.
- R8: `ram_block_o` is 1 from the clock-restore edge up to the resume edge, where it falls. It is 0 at all other times.
- R9: `pd_set_i` has no effect outside the running state or while `chip_rst_i` is high.
- R10: When a reset and a qualifying interrupt are present together during power-down, the reset path is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Restarted oscillator clock |
| rst_ni | input | 1 | Power-on reset of the sequencer, active low, asynchronous |
| chip_rst_i | input | 1 | Chip reset pin, active high |
| pd_set_i | input | 1 | Core write pulse setting the power-down bit |
| int_n_i | input | N_INT | External interrupt request lines, active low |
| int_en_i | input | N_INT | Per-line interrupt enable |
| int_level_i | input | N_INT | Per-line mode, 1 = level-sensitive |
| int_hipri_i | input | N_INT | Per-line top-priority flag |
| reset_ack_i | input | 1 | Reset sequence has taken control |
| pd_bit_o | output | 1 | Power-down control bit |
| osc_enable_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | Core clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| ram_block_o | output | 1 | Internal RAM access block |
| resume_o | output | 1 | One-cycle resume grant |
| resume_isr_o | output | 1 | Service routine follows the resume |
| reset_pending_o | output | 1 | Reset vector follows the resume |

## Verification
Some properties can be checked on every cycle, and the assertions cover those:
- the clocks stay off throughout power-down;
- the core clock is never enabled without the oscillator;
- the reset pin keeps the power-down bit clear;
- the resume grant lasts one cycle, and after an interrupt wake it follows a released line;
- the RAM block is confined to the window between restore and resume.

The directed scenarios cover what needs a sequence of events:
- the exact length of the stabilization wait;
- the rejection of edge, disabled and low-priority requests;
- the difference between a line held past the wait and one released early;
- the asynchronous effect of reset between clock edges;
- reset winning over a simultaneous interrupt;
- the lifetime of the pending-reset flag up to its acknowledge.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [1:0] {
    IDLE_RUN    = 2'd0,
    POWER_DOWN  = 2'd1,
    OSC_RESTART = 2'd2,
    RESUME_WAIT = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_async_flop.sv
// Single flop with an asynchronous override that wins over the clocked path.
module pd_async_flop #(
  parameter logic RST_VAL   = 1'b0,
  parameter logic FORCE_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge force_i) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (force_i) q_o <= FORCE_VAL;
    else              q_o <= d_i;
  end
endmodule

// File: rtl/pd_int_qual.sv
// Wake qualification: enabled, level-sensitive, top-priority, asserted low.
module pd_int_qual #(
  parameter int N_INT = 2,
  localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1
) (
  input  logic [N_INT-1:0] int_n_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic [N_INT-1:0] int_level_i,
  input  logic [N_INT-1:0] int_hipri_i,
  output logic             wake_o,
  output logic [IDX_W-1:0] sel_o
);
  logic [N_INT-1:0] qual;

  for (genvar g = 0; g < N_INT; g++) begin : g_line
    assign qual[g] = ~int_n_i[g] & int_en_i[g] & int_level_i[g] & int_hipri_i[g];
  end

  assign wake_o = |qual;

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = N_INT - 1; i >= 0; i--) begin
      if (qual[i]) sel_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pd_stab_cnt.sv
// Oscillator stabilization counter; done_o after STAB_CYCLES run cycles.
module pd_stab_cnt #(
  parameter int STAB_CYCLES = 16,
  localparam int CNT_W = $clog2(STAB_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CNT_W'(STAB_CYCLES - 1);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_LOAD_NOT_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_i); // R4
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pd_wake_pkg::*;
#(
  parameter int N_INT       = 2,
  parameter int STAB_CYCLES = 16,
  localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chip_rst_i,
  input  logic             pd_set_i,
  input  logic [N_INT-1:0] int_n_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic [N_INT-1:0] int_level_i,
  input  logic [N_INT-1:0] int_hipri_i,
  input  logic             reset_ack_i,
  output logic             pd_bit_o,
  output logic             osc_enable_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             ram_block_o,
  output logic             resume_o,
  output logic             resume_isr_o,
  output logic             reset_pending_o
);
  pd_state_e        state_q, state_d;
  logic             pd_d, osc_d;
  logic             clk_en_q, clk_en_d, pclk_en_q;
  logic             ram_blk_q, ram_blk_d;
  logic             resume_q, resume_d;
  logic             isr_q, isr_d;
  logic             rpend_q, rpend_d;
  logic             wrst_q, wrst_d;
  logic [IDX_W-1:0] wline_q, wline_d;
  logic             int_wake;
  logic [IDX_W-1:0] int_sel;
  logic             cnt_load, cnt_run, cnt_done;

  pd_int_qual #(.N_INT(N_INT)) i_qual (
    .int_n_i     (int_n_i),
    .int_en_i    (int_en_i),
    .int_level_i (int_level_i),
    .int_hipri_i (int_hipri_i),
    .wake_o      (int_wake),
    .sel_o       (int_sel)
  );

  pd_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .run_i  (cnt_run),
    .done_o (cnt_done)
  );

  // reset pin clears the power-down bit without a clock
  pd_async_flop #(.RST_VAL(1'b0), .FORCE_VAL(1'b0)) i_pd_bit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (chip_rst_i),
    .d_i     (pd_d),
    .q_o     (pd_bit_o)
  );

  // reset pin restarts the oscillator without a clock
  pd_async_flop #(.RST_VAL(1'b1), .FORCE_VAL(1'b1)) i_osc_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (chip_rst_i),
    .d_i     (osc_d),
    .q_o     (osc_enable_o)
  );

  always_comb begin
    state_d   = state_q;
    pd_d      = pd_bit_o;
    osc_d     = osc_enable_o;
    clk_en_d  = clk_en_q;
    ram_blk_d = ram_blk_q;
    resume_d  = 1'b0;
    isr_d     = isr_q;
    rpend_d   = rpend_q;
    wrst_d    = wrst_q;
    wline_d   = wline_q;
    cnt_load  = 1'b0;
    cnt_run   = 1'b0;
    unique case (state_q)
      IDLE_RUN: begin
        if (reset_ack_i) rpend_d = 1'b0;
        if (pd_set_i && !chip_rst_i) begin
          state_d  = POWER_DOWN;
          pd_d     = 1'b1;
          osc_d    = 1'b0;
          clk_en_d = 1'b0;
          isr_d    = 1'b0;
        end
      end
      POWER_DOWN: begin
        if (chip_rst_i || !pd_bit_o) begin
          state_d  = OSC_RESTART;
          pd_d     = 1'b0;
          osc_d    = 1'b1;
          cnt_load = 1'b1;
          wrst_d   = 1'b1;
          rpend_d  = 1'b1;
        end else if (int_wake) begin
          state_d  = OSC_RESTART;
          pd_d     = 1'b0;
          osc_d    = 1'b1;
          cnt_load = 1'b1;
          wrst_d   = 1'b0;
          wline_d  = int_sel;
        end
      end
      OSC_RESTART: begin
        cnt_run = 1'b1;
        if (cnt_done) begin
          state_d   = RESUME_WAIT;
          clk_en_d  = 1'b1;
          ram_blk_d = 1'b1;
        end
      end
      RESUME_WAIT: begin
        if (wrst_q || int_n_i[wline_q]) begin
          state_d   = IDLE_RUN;
          resume_d  = 1'b1;
          ram_blk_d = 1'b0;
          isr_d     = !wrst_q;
        end
      end
      default: state_d = IDLE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= IDLE_RUN;
      clk_en_q  <= 1'b1;
      pclk_en_q <= 1'b1;
      ram_blk_q <= 1'b0;
      resume_q  <= 1'b0;
      isr_q     <= 1'b0;
      rpend_q   <= 1'b0;
      wrst_q    <= 1'b0;
      wline_q   <= '0;
    end else begin
      state_q   <= state_d;
      clk_en_q  <= clk_en_d;
      pclk_en_q <= clk_en_d;
      ram_blk_q <= ram_blk_d;
      resume_q  <= resume_d;
      isr_q     <= isr_d;
      rpend_q   <= rpend_d;
      wrst_q    <= wrst_d;
      wline_q   <= wline_d;
    end
  end

  assign cpu_clk_en_o    = clk_en_q;
  assign periph_clk_en_o = pclk_en_q;
  assign ram_block_o     = ram_blk_q;
  assign resume_o        = resume_q;
  assign resume_isr_o    = isr_q;
  assign reset_pending_o = rpend_q;

  AST_PD_CLOCKS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == POWER_DOWN |-> !cpu_clk_en_o && !periph_clk_en_o); // R2
  AST_CLK_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_enable_o); // R4
  AST_RST_HOLDS_PD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_i |-> !pd_bit_o); // R6
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o); // R5
  AST_ISR_RESUME_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o && resume_isr_o |-> $past(int_n_i[wline_q])); // R5
  AST_RAM_BLOCK_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_block_o |-> cpu_clk_en_o && !resume_o && state_q == RESUME_WAIT); // R8
endmodule

// File: tb/test_pd_wake_ctrl.sv
`timescale 1ns/1ps
module test_pd_wake_ctrl;
  localparam int N = 2;
  localparam int S = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         chip_rst_i;
  logic         pd_set_i;
  logic [N-1:0] int_n_i, int_en_i, int_level_i, int_hipri_i;
  logic         reset_ack_i;
  logic pd_bit_o, osc_enable_o, cpu_clk_en_o, periph_clk_en_o;
  logic ram_block_o, resume_o, resume_isr_o, reset_pending_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  pd_wake_ctrl #(.N_INT(N), .STAB_CYCLES(S)) i_pd_wake_ctrl (
    .clk_i, .rst_ni, .chip_rst_i, .pd_set_i, .int_n_i, .int_en_i,
    .int_level_i, .int_hipri_i, .reset_ack_i, .pd_bit_o, .osc_enable_o,
    .cpu_clk_en_o, .periph_clk_en_o, .ram_block_o, .resume_o,
    .resume_isr_o, .reset_pending_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic enter_pd(input string tag);
    pd_set_i = 1'b1;
    tick();
    pd_set_i = 1'b0;
    chk({tag, " R2 pd_bit"}, 32'(pd_bit_o), 1);
    chk({tag, " R2 osc off"}, 32'(osc_enable_o), 0);
    chk({tag, " R2 clocks off"}, {30'd0, cpu_clk_en_o, periph_clk_en_o}, 0);
    chk({tag, " R2 isr flag cleared"}, 32'(resume_isr_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 pd_bit", 32'(pd_bit_o), 0);
    chk("R1 osc", 32'(osc_enable_o), 1);
    chk("R1 clocks", {30'd0, cpu_clk_en_o, periph_clk_en_o}, 3);
    chk("R1 misc", {28'd0, ram_block_o, resume_o, resume_isr_o, reset_pending_o}, 0);
  endtask

  task automatic t_ignored();
    enter_pd("ign");
    int_en_i[0] = 1'b0; int_n_i[0] = 1'b0;
    repeat (3) tick();
    chk("R3 disabled ignored", {30'd0, pd_bit_o, osc_enable_o}, 2);
    int_en_i[0] = 1'b1; int_level_i[0] = 1'b0;
    repeat (3) tick();
    chk("R3 edge mode ignored", {30'd0, pd_bit_o, osc_enable_o}, 2);
    int_level_i[0] = 1'b1; int_hipri_i[0] = 1'b0;
    repeat (3) tick();
    chk("R3 low priority ignored", {30'd0, pd_bit_o, osc_enable_o}, 2);
    chk("R3 clocks stay off", 32'(cpu_clk_en_o), 0);
    int_hipri_i[0] = 1'b1; int_n_i[0] = 1'b1;
    tick();
    chk("R3 released no wake", 32'(pd_bit_o), 1);
  endtask

  task automatic t_int_held(input int line);
    int_n_i[line] = 1'b0;
    tick();
    chk("R4 wake clears pd", 32'(pd_bit_o), 0);
    chk("R4 wake osc on", 32'(osc_enable_o), 1);
    chk("R4 clocks off during wait", 32'(cpu_clk_en_o), 0);
    pd_set_i = 1'b1;
    repeat (S - 1) tick();
    pd_set_i = 1'b0;
    chk("R9 pd_set ignored in restart", 32'(pd_bit_o), 0);
    chk("R4 still waiting", 32'(cpu_clk_en_o), 0);
    tick();
    chk("R4 clocks restored", {30'd0, cpu_clk_en_o, periph_clk_en_o}, 3);
    chk("R8 ram blocked at restore", 32'(ram_block_o), 1);
    repeat (3) tick();
    chk("R5 no resume while held", 32'(resume_o), 0);
    chk("R8 ram blocked while held", 32'(ram_block_o), 1);
    int_n_i[line] = 1'b1;
    tick();
    chk("R5 resume on release", {30'd0, resume_o, resume_isr_o}, 3);
    chk("R8 ram unblocked", 32'(ram_block_o), 0);
    tick();
    chk("R5 resume one cycle", {30'd0, resume_o, resume_isr_o}, 1);
  endtask

  task automatic t_int_early(input int line);
    int_n_i[line] = 1'b0;
    tick();
    chk("R4 wake line", 32'(pd_bit_o), 0);
    int_n_i[line] = 1'b1;
    repeat (S - 1) tick();
    chk("R5 early release still waits", {30'd0, cpu_clk_en_o, resume_o}, 0);
    tick();
    chk("R4 restore after early release", {30'd0, cpu_clk_en_o, resume_o}, 2);
    tick();
    chk("R5 resume next cycle", {30'd0, resume_o, resume_isr_o}, 3);
    tick();
  endtask

  task automatic t_reset_wake();
    #3 chip_rst_i = 1'b1;
    #1;
    chk("R6 async pd clear", 32'(pd_bit_o), 0);
    chk("R6 async osc on", 32'(osc_enable_o), 1);
    tick();
    chk("R7 reset pending", 32'(reset_pending_o), 1);
    chk("R6 pd held clear", 32'(pd_bit_o), 0);
    repeat (S - 1) tick();
    chk("R7 waiting", 32'(cpu_clk_en_o), 0);
    tick();
    chk("R7 restored", {30'd0, cpu_clk_en_o, ram_block_o}, 3);
    tick();
    chk("R7 resume with reset held", {29'd0, resume_o, resume_isr_o, reset_pending_o}, 5);
    chip_rst_i = 1'b0;
    tick();
    chk("R7 pending holds", 32'(reset_pending_o), 1);
    reset_ack_i = 1'b1;
    tick();
    reset_ack_i = 1'b0;
    chk("R7 pending cleared by ack", 32'(reset_pending_o), 0);
  endtask

  task automatic t_simul();
    enter_pd("sim");
    int_n_i[0] = 1'b0;
    chip_rst_i = 1'b1;
    tick();
    chk("R10 reset path taken", 32'(reset_pending_o), 1);
    chip_rst_i = 1'b0;
    int_n_i[0] = 1'b1;
    repeat (S + 1) tick();
    chk("R10 resume without isr", {30'd0, resume_o, resume_isr_o}, 2);
    reset_ack_i = 1'b1;
    tick();
    reset_ack_i = 1'b0;
  endtask

  task automatic t_pd_blocked_by_rst();
    chip_rst_i = 1'b1;
    pd_set_i = 1'b1;
    tick();
    pd_set_i = 1'b0;
    chk("R9 pd_set ignored under reset", {29'd0, pd_bit_o, cpu_clk_en_o, osc_enable_o}, 3);
    chip_rst_i = 1'b0;
    tick();
    chk("R9 still running", {30'd0, pd_bit_o, cpu_clk_en_o}, 1);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; chip_rst_i = 1'b0; pd_set_i = 1'b0; reset_ack_i = 1'b0;
    int_n_i = '1; int_en_i = '1; int_level_i = '1; int_hipri_i = '1;
    repeat (2) @(posedge clk_i);
    #2;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_ignored();
    t_int_held(0);
    enter_pd("early");
    t_int_early(1);
    enter_pd("held1");
    t_int_held(1);
    enter_pd("rst");
    t_reset_wake();
    t_simul();
    t_pd_blocked_by_rst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule